// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the data path of a small 8-bit processor core for its accumulator operations. A sequencer presents the current accumulator, a second operand and the current flag byte, selects one of eight operations with a 3-bit code, and pulses `start`. On that edge the block captures the new accumulator and the new flag byte. The operand can come from a register or from an immediate byte. Four of the operations add or subtract, three are bitwise, and one is a compare.

The block also reports what each operation costs in clock cycles. The cost depends only on where the operand came from. It raises `done` once that many cycles have passed, so the sequencer can pace its own fetch against it. While an operation is timing out, new strobes are refused. The cycle that carries `done` already accepts the next strobe, so back-to-back operations lose no cycle.

Top module: `acc_alu_unit`

## Requirements
- R1: Opcode 0 (add) stores (acc_in + operand) mod 256. Opcode 1 (add with carry) also adds flags_in bit 4. For both, Z is set when the stored value is zero, N is cleared, H is the carry out of bit 3 and C is the carry out of bit 7. H and C are taken over the whole sum including the carry-in, so an operand of 0xFF with carry-in 1 still gives correct flags.
- R2: Opcode 2 (subtract) stores (acc_in - operand) mod 256. Opcode 3 (subtract with borrow) also subtracts flags_in bit 4. For both, Z follows the stored value, N is set, H is the borrow into bit 4 and C is the borrow out of bit 7, taken over operand plus carry-in.
- R3: Opcode 4 (bitwise and) stores acc_in & operand, sets Z when that is zero, clears N, sets H and clears C.
- R4: Opcode 5 (exclusive or) and opcode 6 (inclusive or) store the bitwise result and set Z when it is zero. N, H and C are cleared whatever flags_in holds.
- R5: Opcode 7 (compare) sets flags exactly as opcode 2 would. acc_q receives acc_in unchanged.
- R6: flags_q carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3 to 0 are always zero.
- R7: On an accepted strobe, cost_q becomes 8 when imm_sel is 1 and 4 when imm_sel is 0.
- R8: busy rises on the edge that accepts a strobe. done is a one-cycle pulse that appears exactly cost_q edges after the accepting edge, and busy falls with it.
- R9: A strobe arriving while busy is 1 is ignored. acc_q, flags_q and cost_q hold, and the pending done keeps its timing.
- R10: A strobe in the cycle where done is 1 is accepted. Its results appear on the next edge, with busy 1 and done 0.
- R11: After reset, acc_q, flags_q, cost_q, busy and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation strobe |
| opcode | input | 3 | Operation select (0..7, see R1 to R5) |
| imm_sel | input | 1 | 1 when the operand is an immediate byte |
| acc_in | input | DATA_W (8) | Current accumulator |
| operand | input | DATA_W (8) | Second operand |
| flags_in | input | 8 | Current flag byte |
| acc_q | output | DATA_W (8) | Written-back accumulator |
| flags_q | output | 8 | Written-back flag byte |
| cost_q | output | COST_W (4) | Cycle cost of the last accepted operation |
| busy | output | 1 | Operation timing out |
| done | output | 1 | Cost elapsed, one-cycle pulse |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle: `done` pulses and the timer is free while a fresh `start` is present. The bench provokes this by holding a new strobe ready and driving it in exactly the cycle `done` is high. It then judges that the new results appear on the next edge, with busy set and done cleared, and that the second `done` lands a full cost later. A strobe placed in the middle of a busy window is checked the same way and must leave every output untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   // operation codes, fixed because the sequencer decodes into them
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_XOR = 3'd5,
      OP_OR  = 3'd6,
      OP_CP  = 3'd7
   } alu_op_e;

   // bitwise sub-select carried in opcode[1:0] for codes 4..6
   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_XOR = 2'd1,
      BW_OR  = 2'd2
   } bw_sel_e;

   // flag byte bit positions
   localparam int unsigned FLAG_Z = 7;
   localparam int unsigned FLAG_N = 6;
   localparam int unsigned FLAG_H = 5;
   localparam int unsigned FLAG_C = 4;
   localparam int unsigned FLAG_W = 8;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned DATA_W       = 8,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              half
);

   localparam int unsigned NIB = 4;

   logic [DATA_W:0] wide;
   logic [NIB:0]    nib;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder: subtraction as a + ~b + ~cin, borrows are inverted carries
         logic [DATA_W-1:0] bb;
         logic              ci;
         assign bb    = sub ? ~b : b;
         assign ci    = sub ? ~cin : cin;
         assign wide  = {1'b0, a} + {1'b0, bb} + {{DATA_W{1'b0}}, ci};
         assign nib   = {1'b0, a[NIB-1:0]} + {1'b0, bb[NIB-1:0]} + {{NIB{1'b0}}, ci};
         assign carry = wide[DATA_W] ^ sub;
         assign half  = nib[NIB] ^ sub;
      end else begin : g_split
         // separate adder and subtractor, borrow read straight from the top bit
         logic [DATA_W:0] s_add;
         logic [DATA_W:0] s_sub;
         logic [NIB:0]    n_add;
         logic [NIB:0]    n_sub;
         assign s_add = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         assign s_sub = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
         assign n_add = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
         assign n_sub = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
         assign wide  = sub ? s_sub : s_add;
         assign nib   = sub ? n_sub : n_add;
         assign carry = wide[DATA_W];
         assign half  = nib[NIB];
      end
   endgenerate

   assign res = wide[DATA_W-1:0];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        sel,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      unique case (bw_sel_e'(sel))
         BW_AND:  res = a & b;
         BW_XOR:  res = a ^ b;
         BW_OR:   res = a | b;
         default: res = a | b;
      endcase
   end

endmodule

// File: rtl/alu_cycle_timer.sv
module alu_cycle_timer #(
   parameter int unsigned COST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [COST_W-1:0] cost,
   output logic              busy,
   output logic              done
);

   logic [COST_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else if (load) begin
         remain <= cost;
         busy   <= 1'b1;
         done   <= 1'b0;
      end else if (busy) begin
         if (remain == COST_W'(1)) begin
            remain <= '0;
            busy   <= 1'b0;
            done   <= 1'b1;
         end else begin
            remain <= remain - COST_W'(1);
            done   <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IMM_COST     = 8,
   parameter int unsigned REG_COST     = 4,
   parameter bit          SHARED_ADDER = 1'b1,
   localparam int unsigned COST_W =
      $clog2(((IMM_COST > REG_COST) ? IMM_COST : REG_COST) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        opcode,
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] operand,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] acc_q,
   output logic [FLAG_W-1:0] flags_q,
   output logic [COST_W-1:0] cost_q,
   output logic              busy,
   output logic              done
);

   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("acc_alu_unit: DATA_W must be at least 5 for a bit-3 half carry");
      end
      if (IMM_COST < 2 || REG_COST < 2) begin : g_bad_cost
         $error("acc_alu_unit: operation costs must be at least 2 cycles");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(opcode);

   logic is_sub;
   logic use_carry;
   assign is_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
   assign use_carry = (op == OP_ADC) || (op == OP_SBC);

   logic [DATA_W-1:0] as_res;
   logic              as_c;
   logic              as_h;
   logic [DATA_W-1:0] bw_res;

   alu_addsub #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_addsub (
      .a     (acc_in),
      .b     (operand),
      .cin   (use_carry & flags_in[FLAG_C]),
      .sub   (is_sub),
      .res   (as_res),
      .carry (as_c),
      .half  (as_h)
   );

   alu_bitwise #(
      .DATA_W (DATA_W)
   ) u_bitwise (
      .a   (acc_in),
      .b   (operand),
      .sel (opcode[1:0]),
      .res (bw_res)
   );

   logic [DATA_W-1:0] nxt_acc;
   logic [FLAG_W-1:0] nxt_flg;

   always_comb begin
      nxt_acc = acc_in;
      nxt_flg = '0;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            nxt_acc         = as_res;
            nxt_flg[FLAG_Z] = ~|as_res;
            nxt_flg[FLAG_N] = is_sub;
            nxt_flg[FLAG_H] = as_h;
            nxt_flg[FLAG_C] = as_c;
         end
         OP_AND, OP_XOR, OP_OR: begin
            nxt_acc         = bw_res;
            nxt_flg[FLAG_Z] = ~|bw_res;
            nxt_flg[FLAG_H] = (op == OP_AND);
         end
         OP_CP: begin
            nxt_acc         = acc_in;
            nxt_flg[FLAG_Z] = ~|as_res;
            nxt_flg[FLAG_N] = 1'b1;
            nxt_flg[FLAG_H] = as_h;
            nxt_flg[FLAG_C] = as_c;
         end
         default: ;
      endcase
   end

   logic              accept;
   logic [COST_W-1:0] nxt_cost;
   assign accept   = start & ~busy;
   assign nxt_cost = imm_sel ? COST_W'(IMM_COST) : COST_W'(REG_COST);

   alu_cycle_timer #(
      .COST_W (COST_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .cost  (nxt_cost),
      .busy  (busy),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         flags_q <= '0;
         cost_q  <= '0;
      end else if (accept) begin
         acc_q   <= nxt_acc;
         flags_q <= nxt_flg;
         cost_q  <= nxt_cost;
      end
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IMM_COST = 8,
   parameter int unsigned REG_COST = 4,
   parameter int unsigned COST_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        opcode,
   input logic              imm_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [7:0]        flags_q,
   input logic [DATA_W-1:0] acc_q,
   input logic [COST_W-1:0] cost_q,
   input logic              busy,
   input logic              done
);

   a_r6_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[3:0] == 4'h0);

   a_r7_cost_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> cost_q == ($past(imm_sel) ? COST_W'(IMM_COST) : COST_W'(REG_COST)));

   a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(acc_q) && $stable(flags_q) && $stable(cost_q)));

   a_r5_compare_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode == 3'd7) |=> acc_q == $past(acc_in));

   a_r3_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode == 3'd4) |=> (flags_q[5] && !flags_q[4] && !flags_q[6]));

endmodule

bind acc_alu_unit acc_alu_chk #(
   .DATA_W   (DATA_W),
   .IMM_COST (IMM_COST),
   .REG_COST (REG_COST),
   .COST_W   (COST_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .opcode  (opcode),
   .imm_sel (imm_sel),
   .acc_in  (acc_in),
   .flags_q (flags_q),
   .acc_q   (acc_q),
   .cost_q  (cost_q),
   .busy    (busy),
   .done    (done)
);

// File: tb/sim_acc_alu_unit.sv
`timescale 1ns/1ps
module sim_acc_alu_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] opcode = 3'd0;
   logic       imm_sel = 1'b0;
   logic [7:0] acc_in = 8'h00;
   logic [7:0] operand = 8'h00;
   logic [7:0] flags_in = 8'h00;
   logic [7:0] acc_q;
   logic [7:0] flags_q;
   logic [3:0] cost_q;
   logic       busy;
   logic       done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   acc_alu_unit u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .opcode   (opcode),
      .imm_sel  (imm_sel),
      .acc_in   (acc_in),
      .operand  (operand),
      .flags_in (flags_in),
      .acc_q    (acc_q),
      .flags_q  (flags_q),
      .cost_q   (cost_q),
      .busy     (busy),
      .done     (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // integer model written from the requirements
   function automatic void model(input int op, input int a, input int b, input int fin,
                                 output int ra, output int rf);
      int c, s, z, n, h, cy;
      c = (fin >> 4) & 1;
      n = 0; h = 0; cy = 0; ra = a;
      case (op)
         0, 1: begin
            if (op == 0) c = 0;
            s  = a + b + c;
            h  = (((a & 15) + (b & 15) + c) > 15) ? 1 : 0;
            cy = (s > 255) ? 1 : 0;
            ra = s & 255;
         end
         2, 3, 7: begin
            if (op == 2 || op == 7) c = 0;
            s  = a - b - c;
            n  = 1;
            h  = (((a & 15) - (b & 15) - c) < 0) ? 1 : 0;
            cy = (s < 0) ? 1 : 0;
            ra = (op == 7) ? a : (s & 255);
            z  = ((s & 255) == 0) ? 1 : 0;
         end
         4: begin ra = a & b; h = 1; end
         5: ra = a ^ b;
         default: ra = a | b;
      endcase
      if (op != 7) z = (ra == 0) ? 1 : 0;
      rf = (z << 7) | (n << 6) | (h << 5) | (cy << 4);
   endfunction

   task automatic drive(input int op, input bit imm, input int a, input int b, input int fin);
      opcode   = op[2:0];
      imm_sel  = imm;
      acc_in   = a[7:0];
      operand  = b[7:0];
      flags_in = fin[7:0];
      start    = 1'b1;
   endtask

   // one operation from idle: results, cost, done timing
   task automatic run_op(input int op, input bit imm, input int a, input int b,
                         input int fin, input string req);
      int ea, ef, cost;
      model(op, a, b, fin, ea, ef);
      cost = imm ? 8 : 4;
      @(negedge clk);
      drive(op, imm, a, b, fin);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(acc_q == ea[7:0], req, acc_q, ea);
      chk(flags_q == ef[7:0], {req, " flags"}, flags_q, ef);
      chk(cost_q == cost[3:0], "R7", cost_q, cost);
      for (int k = 1; k < cost; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      chk(!done && busy, "R8 early", {busy, done}, 2'b10);
      @(posedge clk);
      @(negedge clk);
      chk(done && !busy, "R8 done", {busy, done}, 2'b01);
      @(posedge clk);
      @(negedge clk);
      chk(!done, "R8 pulse", done, 0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(acc_q == 8'h00 && flags_q == 8'h00 && cost_q == 4'h0 && !busy && !done,
          "R11", {acc_q, flags_q}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_arith;
      run_op(0, 1'b1, 8'h3A, 8'hC6, 8'h00, "R1 add wrap");      // 0x00, flags 0xB0
      run_op(1, 1'b0, 8'h10, 8'hFF, 8'h10, "R1 adc ff+1");      // 0x10, flags 0x30
      run_op(0, 1'b0, 8'h12, 8'h34, 8'hF0, "R1 add plain");
      run_op(2, 1'b1, 8'h3E, 8'h0F, 8'h00, "R2 sub half");      // 0x2F, flags 0x60
      run_op(3, 1'b0, 8'h00, 8'hFF, 8'h10, "R2 sbc ff+1");      // 0x00, flags 0xF0
      run_op(3, 1'b1, 8'h50, 8'h20, 8'h00, "R2 sbc no carry");
   endtask

   task automatic t_logic;
      run_op(4, 1'b1, 8'h5A, 8'hA5, 8'h00, "R3 and zero");      // flags 0xA0
      run_op(4, 1'b0, 8'hF3, 8'h3C, 8'hD0, "R3 and");
      run_op(5, 1'b1, 8'hFF, 8'h0F, 8'hF0, "R4 xor");           // flags 0x00
      run_op(6, 1'b0, 8'h00, 8'h00, 8'h70, "R4 or zero");       // flags 0x80
      run_op(6, 1'b1, 8'h81, 8'h18, 8'hF0, "R4 or");
   endtask

   task automatic t_compare;
      run_op(7, 1'b1, 8'h3C, 8'h40, 8'h00, "R5 cp below");      // acc 0x3C, flags 0x50
      run_op(7, 1'b0, 8'h77, 8'h77, 8'h10, "R5 cp equal");      // flags 0xC0
      chk(flags_q[3:0] == 4'h0, "R6", flags_q, flags_q & 8'hF0);
   endtask

   task automatic t_busy_ignore;
      int ea, ef;
      model(0, 8'h01, 8'h02, 0, ea, ef);
      @(negedge clk);
      drive(0, 1'b1, 8'h01, 8'h02, 8'h00);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      drive(6, 1'b0, 8'hF0, 8'h0F, 8'h00);   // edge 2 sees a strobe while busy
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(acc_q == ea[7:0] && flags_q == ef[7:0] && cost_q == 4'd8, "R9 hold",
          {acc_q, flags_q}, {ea[7:0], ef[7:0]});
      for (int k = 3; k < 8; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      chk(!done, "R9 no early done", done, 0);
      @(posedge clk);
      @(negedge clk);
      chk(done, "R9 done on time", done, 1);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_collision;
      int ea, ef;
      @(negedge clk);
      drive(0, 1'b0, 8'h20, 8'h05, 8'h00);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k < 4; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      chk(done, "R10 first done", done, 1);
      model(2, 8'h44, 8'h45, 0, ea, ef);
      drive(2, 1'b1, 8'h44, 8'h45, 8'h00);   // strobe in the done cycle
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(acc_q == ea[7:0] && flags_q == ef[7:0], "R10 accepted",
          {acc_q, flags_q}, {ea[7:0], ef[7:0]});
      chk(busy && !done, "R10 busy", {busy, done}, 2'b10);
      for (int k = 1; k < 8; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      chk(done, "R10 second done", done, 1);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_logic();
      t_compare();
      t_busy_ignore();
      t_collision();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule